// File: doc/BRIEF.md
# Processing-Element Array Master Controller

This block is the global controller of a rectangular array of processing elements that together step a finite-difference grid. Each element owns one fixed rectangular tile of grid nodes. When reset is released, the controller configures the array on a dedicated configuration bus, one write per cycle. Every element is told how many nodes it owns and which of its four neighbours it exchanges boundary values with. The order of those exchanges is the bit order of that neighbour mask. After the configuration writes, the controller raises a single start pulse that reaches every element at once.

Once the array is running, the controller accepts host commands over a valid/ready handshake. A command names a global grid coordinate (x, y). The controller splits it by bit slicing into the index of the owning element and a local node address. A read command becomes a one-cycle read request to that element, and the element's word is returned to the host with a one-cycle response pulse. An excitation command is held on a separate excitation bus. It waits for the next iteration that the array starts and stays asserted until that iteration reports completion. Only one read is in flight at a time. A second excitation is refused while the first has not yet been used up.

Top module: `arr_main_ctrl`

## Requirements
- R1: After reset is released, the controller issues 2×PX×PY configuration writes on consecutive cycles. Element indices run in ascending order from 0. For each element, the first write has kind 0 and the second has kind 1. During each write exactly one bit of the one-hot select, the element's bit, is set.
- R2: A kind-0 write carries BW×BH. A kind-1 write carries a neighbour mask for element e = ey×PX + ex. Bit 0 is set if ex > 0, bit 1 if ex < PX−1, bit 2 if ey > 0 and bit 3 if ey < PY−1. All higher bits are zero.
- R3: The start output is high for exactly one cycle, in the cycle right after the last configuration write, and never again until the next reset.
- R4: For an accepted read of (x, y), the request strobe is high in the cycle after acceptance. In that cycle the select has only bit (y/BH)×PX + x/BW set, and the address is (y mod BH)×BW + (x mod BW). The element's data word is sampled one cycle after the request. The host response pulse is high for one cycle, three cycles after the accepting edge, and carries that word.
- R5: Host ready stays low from reset until the start pulse has been issued.
- R6: After a read is accepted, ready stays low until the response pulse has been given. It returns high in the following cycle.
- R7: An accepted excitation drives its element select, local address and value on the excitation bus. Its enable stays low until the first iteration-start pulse that falls strictly after the accepting cycle. It is then high from the next cycle until the cycle after the iteration-done pulse.
- R8: While an excitation is waiting or active, ready is low for excitation commands but stays high for read commands.
- R9: While reset is asserted, ready, start, configuration write, read request, response pulse and excitation enable are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hostValid | input | 1 | Host command valid |
| hostReady | output | 1 | Controller can take the command |
| hostIsExcite | input | 1 | 1 = excitation, 0 = read |
| hostX | input | clog2(PX·BW) | Global column |
| hostY | input | clog2(PY·BH) | Global row |
| hostWdata | input | DW | Excitation value |
| hostRspValid | output | 1 | One-cycle read response pulse |
| hostRspData | output | DW | Read response word |
| cfgWr | output | 1 | Configuration write strobe |
| cfgSel | output | PX·PY | One-hot element select for configuration |
| cfgKind | output | 1 | 0 = node count, 1 = neighbour mask |
| cfgData | output | CW | Configuration value |
| peStart | output | 1 | Broadcast start pulse |
| peRdReq | output | 1 | Read request strobe |
| peSel | output | PX·PY | One-hot element select for reads |
| peAddr | output | clog2(BW)+clog2(BH) | Local node address for reads |
| peRdata | input | PX·PY·DW | Read words of all elements, element e at bits e·DW upward |
| iterStart | input | 1 | Array iteration began |
| iterDone | input | 1 | Array iteration finished |
| excEn | output | 1 | Excitation applies to the current iteration |
| excSel | output | PX·PY | One-hot element select for the excitation |
| excAddr | output | clog2(BW)+clog2(BH) | Local node address for the excitation |
| excVal | output | DW | Excitation value |

## Verification
The hardest situation to reach is an excitation whose acceptance falls in the same cycle as an iteration-start pulse. That start must not arm it; only a later start may. The bench lines the command's accepting edge up with a start pulse and then checks that the enable stays low until a separate start arrives. It also sends a read while an excitation is waiting, to show the two paths share the handshake without blocking each other. Every grid coordinate of the default configuration is read back against a memory model whose words encode element and address.

// File: rtl/arr_ctrl_pkg.sv
package arr_ctrl_pkg;

  typedef enum logic [1:0] {PH_BOOT, PH_INIT, PH_START, PH_RUN} phase_e;
  typedef enum logic [1:0] {RD_IDLE, RD_ISSUE, RD_CAP, RD_RSP} rdState_e;
  typedef enum logic [1:0] {EX_FREE, EX_PEND, EX_ACT} exState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cfgWr;
    logic cfgKind;
    logic startPulse;
    logic rdLatch;
    logic rdIssue;
    logic rdCapture;
    logic rspFire;
    logic excLatch;
    logic excEnable;
  } ctrlStrobe_t;

endpackage

// File: rtl/arr_ctrl_fsm.sv
module arr_ctrl_fsm
  import arr_ctrl_pkg::*;
#(
  parameter int NPE = 4,
  parameter int IW  = (NPE > 1) ? $clog2(NPE) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hostValid,
  input  logic          hostIsExcite,
  input  logic          iterStart,
  input  logic          iterDone,
  output logic          hostReady,
  output logic [IW-1:0] cfgIdx,
  output ctrlStrobe_t   strobe
);

  localparam logic [IW:0] CNT_LAST = (IW+1)'(2*NPE-1);

  phase_e      phase;
  rdState_e    rdState;
  exState_e    exState;
  logic [IW:0] initCnt;
  logic        accept;

  assign hostReady = (phase == PH_RUN) && (rdState == RD_IDLE) &&
                     (!hostIsExcite || exState == EX_FREE);
  assign accept = hostValid && hostReady;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_BOOT;
      initCnt <= '0;
    end else begin
      unique case (phase)
        PH_BOOT:  phase <= PH_INIT;
        PH_INIT: begin
          initCnt <= initCnt + 1'b1;
          if (initCnt == CNT_LAST) phase <= PH_START;
        end
        PH_START: phase <= PH_RUN;
        default:  phase <= PH_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdState <= RD_IDLE;
    else begin
      unique case (rdState)
        RD_IDLE:  if (accept && !hostIsExcite) rdState <= RD_ISSUE;
        RD_ISSUE: rdState <= RD_CAP;
        RD_CAP:   rdState <= RD_RSP;
        default:  rdState <= RD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exState <= EX_FREE;
    else begin
      unique case (exState)
        EX_FREE: if (accept && hostIsExcite) exState <= EX_PEND;
        EX_PEND: if (iterStart) exState <= EX_ACT;
        default: if (iterDone) exState <= EX_FREE;
      endcase
    end
  end

  assign cfgIdx = initCnt[IW:1];

  always_comb begin
    strobe            = '0;
    strobe.cfgWr      = (phase == PH_INIT);
    strobe.cfgKind    = initCnt[0];
    strobe.startPulse = (phase == PH_START);
    strobe.rdLatch    = accept && !hostIsExcite;
    strobe.rdIssue    = (rdState == RD_ISSUE);
    strobe.rdCapture  = (rdState == RD_CAP);
    strobe.rspFire    = (rdState == RD_RSP);
    strobe.excLatch   = accept && hostIsExcite;
    strobe.excEnable  = (exState == EX_ACT);
  end

  AST_START_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.startPulse |=> !strobe.startPulse); // R3

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (hostValid && hostReady && !hostIsExcite) |=> !hostReady); // R6

  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.rspFire |-> $past(strobe.rdIssue, 2)); // R4

  AST_EXC_ARM_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe.excEnable) |-> $past(iterStart)); // R7

endmodule

// File: rtl/arr_ctrl_dp.sv
module arr_ctrl_dp
  import arr_ctrl_pkg::*;
#(
  parameter int PX  = 2,
  parameter int PY  = 2,
  parameter int BW  = 4,
  parameter int BH  = 4,
  parameter int DW  = 16,
  parameter int CW  = 8,
  parameter int NPE = PX * PY,
  parameter int IW  = (NPE > 1) ? $clog2(NPE) : 1,
  parameter int LXW = $clog2(BW),
  parameter int LYW = $clog2(BH),
  parameter int XW  = $clog2(PX * BW),
  parameter int YW  = $clog2(PY * BH),
  parameter int AW  = LXW + LYW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobe,
  input  logic [IW-1:0]     cfgIdx,
  input  logic [XW-1:0]     hostX,
  input  logic [YW-1:0]     hostY,
  input  logic [DW-1:0]     hostWdata,
  input  logic [NPE*DW-1:0] peRdata,
  output logic              cfgWr,
  output logic [NPE-1:0]    cfgSel,
  output logic              cfgKind,
  output logic [CW-1:0]     cfgData,
  output logic              peStart,
  output logic              peRdReq,
  output logic [NPE-1:0]    peSel,
  output logic [AW-1:0]     peAddr,
  output logic              hostRspValid,
  output logic [DW-1:0]     hostRspData,
  output logic              excEn,
  output logic [NPE-1:0]    excSel,
  output logic [AW-1:0]     excAddr,
  output logic [DW-1:0]     excVal
);

  logic [IW-1:0] decIdx;
  logic [AW-1:0] decAddr;
  logic [IW-1:0] rdIdx, exIdx;
  logic [AW-1:0] rdAddr;
  logic [DW-1:0] rspData;
  logic [DW-1:0] rdWord [NPE];

  // tile index and in-tile address by bit slicing (powers of two)
  assign decIdx  = IW'(int'(hostY[YW-1:LYW]) * PX + int'(hostX[XW-1:LXW]));
  assign decAddr = {hostY[LYW-1:0], hostX[LXW-1:0]};

  function automatic logic [3:0] linkMask(input logic [IW-1:0] idx);
    int cx, cy;
    cx = int'(idx) % PX;
    cy = int'(idx) / PX;
    return {cy < PY-1, cy > 0, cx < PX-1, cx > 0};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdIdx   <= '0;
      rdAddr  <= '0;
      exIdx   <= '0;
      excAddr <= '0;
      excVal  <= '0;
      rspData <= '0;
    end else begin
      if (strobe.rdLatch) begin
        rdIdx  <= decIdx;
        rdAddr <= decAddr;
      end
      if (strobe.excLatch) begin
        exIdx   <= decIdx;
        excAddr <= decAddr;
        excVal  <= hostWdata;
      end
      if (strobe.rdCapture) rspData <= rdWord[rdIdx];
    end
  end

  for (genvar g = 0; g < NPE; g++) begin : g_elem
    assign rdWord[g] = peRdata[g*DW +: DW];
    assign cfgSel[g] = strobe.cfgWr && (cfgIdx == IW'(g));
    assign peSel[g]  = strobe.rdIssue && (rdIdx == IW'(g));
    assign excSel[g] = strobe.excEnable && (exIdx == IW'(g));
  end

  assign cfgWr        = strobe.cfgWr;
  assign cfgKind      = strobe.cfgKind;
  assign cfgData      = strobe.cfgKind ? CW'(linkMask(cfgIdx)) : CW'(BW * BH);
  assign peStart      = strobe.startPulse;
  assign peRdReq      = strobe.rdIssue;
  assign peAddr       = rdAddr;
  assign hostRspValid = strobe.rspFire;
  assign hostRspData  = rspData;
  assign excEn        = strobe.excEnable;

  AST_RD_SEL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    peRdReq |-> ($countones(peSel) == 1)); // R4

  AST_EXC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (excEn && $past(excEn)) |-> ($stable(excAddr) && $stable(excVal) && $stable(excSel))); // R7

  AST_CFG_SEL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfgWr |-> ($countones(cfgSel) == 1)); // R1

endmodule

// File: rtl/arr_main_ctrl.sv
module arr_main_ctrl
  import arr_ctrl_pkg::*;
#(
  parameter int PX = 2,
  parameter int PY = 2,
  parameter int BW = 4,
  parameter int BH = 4,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               hostValid,
  output logic                               hostReady,
  input  logic                               hostIsExcite,
  input  logic [$clog2(PX*BW)-1:0]           hostX,
  input  logic [$clog2(PY*BH)-1:0]           hostY,
  input  logic [DW-1:0]                      hostWdata,
  output logic                               hostRspValid,
  output logic [DW-1:0]                      hostRspData,
  output logic                               cfgWr,
  output logic [PX*PY-1:0]                   cfgSel,
  output logic                               cfgKind,
  output logic [CW-1:0]                      cfgData,
  output logic                               peStart,
  output logic                               peRdReq,
  output logic [PX*PY-1:0]                   peSel,
  output logic [$clog2(BW)+$clog2(BH)-1:0]   peAddr,
  input  logic [PX*PY*DW-1:0]                peRdata,
  input  logic                               iterStart,
  input  logic                               iterDone,
  output logic                               excEn,
  output logic [PX*PY-1:0]                   excSel,
  output logic [$clog2(BW)+$clog2(BH)-1:0]   excAddr,
  output logic [DW-1:0]                      excVal
);

  localparam int NPE = PX * PY;
  localparam int IW  = (NPE > 1) ? $clog2(NPE) : 1;

  ctrlStrobe_t   strobe;
  logic [IW-1:0] cfgIdx;

  arr_ctrl_fsm #(.NPE(NPE), .IW(IW)) fsm_i (
    .clk(clk), .rst_n(rst_n),
    .hostValid(hostValid), .hostIsExcite(hostIsExcite),
    .iterStart(iterStart), .iterDone(iterDone),
    .hostReady(hostReady), .cfgIdx(cfgIdx), .strobe(strobe)
  );

  arr_ctrl_dp #(.PX(PX), .PY(PY), .BW(BW), .BH(BH), .DW(DW), .CW(CW)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .cfgIdx(cfgIdx),
    .hostX(hostX), .hostY(hostY), .hostWdata(hostWdata), .peRdata(peRdata),
    .cfgWr(cfgWr), .cfgSel(cfgSel), .cfgKind(cfgKind), .cfgData(cfgData),
    .peStart(peStart), .peRdReq(peRdReq), .peSel(peSel), .peAddr(peAddr),
    .hostRspValid(hostRspValid), .hostRspData(hostRspData),
    .excEn(excEn), .excSel(excSel), .excAddr(excAddr), .excVal(excVal)
  );

  AST_HOLD_OFF_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWr || peStart) |-> !hostReady); // R5

endmodule

// File: tb/arr_main_ctrl_tb_top.sv
`timescale 1ns/100ps
module arr_main_ctrl_tb_top;

  localparam int PX = 2, PY = 2, BW = 4, BH = 4, DW = 16, CW = 8;
  localparam int NPE = PX * PY;

  logic clk = 0;
  logic rst_n = 0;
  logic hostValid = 0, hostIsExcite = 0;
  logic [2:0] hostX = 0, hostY = 0;
  logic [DW-1:0] hostWdata = 0;
  logic hostReady, hostRspValid;
  logic [DW-1:0] hostRspData;
  logic cfgWr, cfgKind, peStart, peRdReq, excEn;
  logic [NPE-1:0] cfgSel, peSel, excSel;
  logic [CW-1:0] cfgData;
  logic [3:0] peAddr, excAddr;
  logic [DW-1:0] excVal;
  logic [NPE*DW-1:0] peRdata = '0;
  logic iterStart = 0, iterDone = 0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  arr_main_ctrl #(.PX(PX), .PY(PY), .BW(BW), .BH(BH), .DW(DW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .hostValid(hostValid), .hostReady(hostReady),
    .hostIsExcite(hostIsExcite), .hostX(hostX), .hostY(hostY), .hostWdata(hostWdata),
    .hostRspValid(hostRspValid), .hostRspData(hostRspData),
    .cfgWr(cfgWr), .cfgSel(cfgSel), .cfgKind(cfgKind), .cfgData(cfgData),
    .peStart(peStart), .peRdReq(peRdReq), .peSel(peSel), .peAddr(peAddr),
    .peRdata(peRdata), .iterStart(iterStart), .iterDone(iterDone),
    .excEn(excEn), .excSel(excSel), .excAddr(excAddr), .excVal(excVal)
  );

  function automatic logic [DW-1:0] memVal(int e, int a);
    return DW'(e * 1000 + a * 7 + 5);
  endfunction

  // element memory model: one-cycle read latency
  always @(posedge clk) begin
    for (int e = 0; e < NPE; e++)
      if (peRdReq && peSel[e]) peRdata[e*DW +: DW] <= memVal(e, int'(peAddr));
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitReady();
    for (int i = 0; i < 50 && !hostReady; i++) @(negedge clk);
  endtask

  task automatic doRead(input int x, input int y);
    int lat, e, a;
    hostIsExcite = 0; hostX = 3'(x); hostY = 3'(y); hostValid = 1;
    waitReady();
    @(posedge clk); #1 hostValid = 0;
    lat = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); lat++;
      if (lat == 1) chk(!hostReady, "R6", hostReady, 0);
      if (hostRspValid) break;
    end
    e = (y / BH) * PX + x / BW;
    a = (y % BH) * BW + x % BW;
    chk(lat == 3, "R4", lat, 3);
    chk(hostRspData == memVal(e, a), "R4", hostRspData, memVal(e, a));
    @(negedge clk);
    chk(hostReady && !hostRspValid, "R6", hostReady, 1);
  endtask

  task automatic sendExcite(input int x, input int y, input int v, input bit withStart);
    hostIsExcite = 1; hostX = 3'(x); hostY = 3'(y); hostWdata = DW'(v); hostValid = 1;
    waitReady();
    if (withStart) iterStart = 1;
    @(posedge clk); #1 hostValid = 0; iterStart = 0; hostIsExcite = 0;
  endtask

  task automatic pulse(input bit isStart);
    if (isStart) iterStart = 1; else iterDone = 1;
    @(negedge clk);
    iterStart = 0; iterDone = 0;
  endtask

  task automatic chkExc(input int x, input int y, input int v);
    int e, a;
    e = (y / BH) * PX + x / BW;
    a = (y % BH) * BW + x % BW;
    chk(excEn == 1, "R7", excEn, 1);
    chk(excSel == NPE'(1 << e), "R7", excSel, 1 << e);
    chk(excAddr == 4'(a), "R7", excAddr, a);
    chk(excVal == DW'(v), "R7", excVal, v);
  endtask

  initial begin
    int k, starts, expData;
    bit readyEarly;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk(!hostReady && !peStart && !cfgWr && !peRdReq && !hostRspValid && !excEn,
        "R9", {hostReady, peStart, cfgWr, peRdReq, hostRspValid, excEn}, 0);
    @(posedge clk); #1 rst_n = 1;
    k = 0; starts = 0; readyEarly = 0;
    for (int c = 0; c < 2 * NPE + 4; c++) begin
      @(negedge clk);
      if (starts == 0 && hostReady) readyEarly = 1;
      if (cfgWr) begin
        chk(cfgSel == NPE'(1 << (k / 2)), "R1", cfgSel, 1 << (k / 2));
        chk(cfgKind == k[0], "R1", cfgKind, k % 2);
        if (k % 2 == 0) expData = BW * BH;
        else expData = int'((k / 2) % PX > 0) | (int'((k / 2) % PX < PX - 1) << 1)
                     | (int'((k / 2) / PX > 0) << 2) | (int'((k / 2) / PX < PY - 1) << 3);
        chk(cfgData == CW'(expData), "R2", cfgData, expData);
        k++;
      end
      if (peStart) begin
        starts++;
        chk(k == 2 * NPE, "R3", k, 2 * NPE);
      end
    end
    chk(k == 2 * NPE, "R1", k, 2 * NPE);
    chk(starts == 1, "R3", starts, 1);
    chk(!readyEarly, "R5", readyEarly, 0);
    chk(hostReady, "R5", hostReady, 1);

    // full read sweep over the grid
    for (int y = 0; y < PY * BH; y++)
      for (int x = 0; x < PX * BW; x++)
        doRead(x, y);

    // excitation waits for a start that follows acceptance
    @(negedge clk);
    sendExcite(5, 6, 16'h1234, 0);
    @(negedge clk);
    chk(!excEn, "R7", excEn, 0);
    hostIsExcite = 1;
    #0.1 chk(!hostReady, "R8", hostReady, 0);
    hostIsExcite = 0;
    #0.1 chk(hostReady, "R8", hostReady, 1);
    doRead(1, 2);
    chk(!excEn, "R7", excEn, 0);
    pulse(1);
    chkExc(5, 6, 16'h1234);
    repeat (3) @(negedge clk);
    chkExc(5, 6, 16'h1234);
    hostIsExcite = 1;
    #0.1 chk(!hostReady, "R8", hostReady, 0);
    hostIsExcite = 0;
    pulse(0);
    chk(!excEn && excSel == 0, "R7", excEn, 0);
    hostIsExcite = 1;
    #0.1 chk(hostReady, "R8", hostReady, 1);
    hostIsExcite = 0;

    // acceptance coinciding with a start pulse must not arm it
    @(negedge clk);
    sendExcite(2, 1, 16'h00A5, 1);
    @(negedge clk);
    chk(!excEn, "R7", excEn, 0);
    repeat (2) @(negedge clk);
    chk(!excEn, "R7", excEn, 0);
    pulse(1);
    chkExc(2, 1, 16'h00A5);
    pulse(0);
    chk(!excEn, "R7", excEn, 0);

    // excitation on the opposite corner tile
    sendExcite(0, 7, 16'h7777, 0);
    @(negedge clk);
    pulse(1);
    chkExc(0, 7, 16'h7777);
    pulse(0);
    chk(!excEn, "R7", excEn, 0);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule